// File: doc/BRIEF.md
# Reloadable Register-Controlled Clock Divider

This block derives a gated peripheral clock from its parent clock by an integer ratio. Software programs a new ratio into a staging field of a ratio register. The staged value has no effect on its own. It is copied into the divider only while the control register holds both this clock's reload-force bit and the global reload trigger bit. The divider then takes the new ratio at its next terminal count, so every output period has either the old length or the new one. An enable bit in the control register gates the output. The gate opens and closes only during a low phase of the divided clock.

Only ratios 4, 5, 6 and 8 are legal. A staged value below 4 is raised to 4, and a value of 7 or more becomes 8. Once the change has settled, software clears the reload-force byte and the trigger bit together. The active ratio keeps its value through that clear. The register port is a plain single-cycle write strobe with a combinational read. The clock output is a plain registered pin. Neither carries a stream, so neither has valid/ready handshaking.

Top module: `reload_clkdiv`

## Requirements
- R1: After reset, clk_out is low, the control register reads 0, the ratio register reads 0x0000_0800, and the active ratio is 8, which is seen once the output is enabled.
- R2: The control register is at word address 0 and the ratio register at word address 8. Both store and read back all 32 bits. Any other address reads 0 and ignores writes.
- R3: The staged ratio is bits [13:8] of the ratio register. The other bits of that register are stored but have no effect on the output.
- R4: The trigger bit (control bit 8) alone does not apply the staged ratio. This clock's reload-force bit (control bit 1) alone does not apply it either.
- R5: While control bits 8 and 1 are both set, the staged ratio becomes active at the next terminal count. Clearing control bits [8:0] afterwards leaves the active ratio unchanged.
- R6: A staged value of 0 to 3 is applied as 4. A staged value of 7 to 63 is applied as 8. The values 4, 5 and 6 are applied unchanged.
- R7: For an active ratio N, clk_out is high for floor(N/2) parent cycles and low for the remaining N - floor(N/2). An even N therefore gives a 50% duty cycle.
- R8: Control bit 25 enables the output. While this bit is clear, clk_out stays low. The gate changes only during a low phase, so a high pulse in progress always completes at full length.
- R9: The active ratio changes only at a terminal count of the divider. No high or low phase of clk_out is ever shorter than 2 parent cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe; writes bus_wdata to bus_addr on the rising edge |
| bus_addr | input | 4 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| clk_out | output | 1 | Divided, gated clock, driven from a register |

## Verification
The embedded assertions check four things on every cycle. The active ratio is always one of the four legal values and is the only bound on the counter. The ratio changes only when the counter wraps. A pending reload is raised only by a reload request. Neither phase of clk_out lasts a single cycle. The bench's scenarios are needed for the rest: the exact high and low lengths for each ratio, the clamping of illegal values, and the rule that trigger or force alone does nothing. They also show that the active ratio holds through the clear of the low control byte, and that disabling in mid-pulse lets the pulse finish before the output stays low.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;
  localparam int RATIO_W = 6;

  // Map any staged value onto the legal ratio set {4,5,6,8}
  function automatic logic [RATIO_W-1:0] legal_ratio(input logic [RATIO_W-1:0] r);
    if (r < RATIO_W'(4))      return RATIO_W'(4);
    else if (r > RATIO_W'(6)) return RATIO_W'(8);
    else                      return r;
  endfunction
endpackage

// File: rtl/ckdiv_regs.sv
module ckdiv_regs #(
  parameter int AW         = 4,
  parameter int DW         = 32,
  parameter int CTRL_ADDR  = 0,
  parameter int RATIO_ADDR = 8,
  parameter int CLK_IDX    = 1,
  parameter int EN_BASE    = 24,
  parameter int TRIG_BIT   = 8,
  parameter int FIELD_LSB  = 8,
  parameter int RW         = 6,
  parameter int RESET_RAT  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [RW-1:0] staged,
  output logic          enable,
  output logic          reload_req
);
  localparam int EN_BIT = EN_BASE + CLK_IDX;
  localparam logic [DW-1:0] RATIO_RST = DW'(RESET_RAT) << FIELD_LSB;

  logic [DW-1:0] ctrl_q, ratio_q;
  logic          hit_ctrl, hit_ratio;

  assign hit_ctrl  = (bus_addr == AW'(CTRL_ADDR));
  assign hit_ratio = (bus_addr == AW'(RATIO_ADDR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ratio_q <= RATIO_RST;
    end else if (bus_we) begin
      if (hit_ctrl)  ctrl_q  <= bus_wdata;
      if (hit_ratio) ratio_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl)  bus_rdata = ctrl_q;
    if (hit_ratio) bus_rdata = ratio_q;
  end

  assign staged     = ratio_q[FIELD_LSB +: RW];
  assign enable     = ctrl_q[EN_BIT];
  assign reload_req = ctrl_q[TRIG_BIT] & ctrl_q[CLK_IDX];
endmodule

// File: rtl/ckdiv_count.sv
module ckdiv_count
  import ckdiv_pkg::*;
#(
  parameter int RW        = RATIO_W,
  parameter int RESET_RAT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload_req,
  input  logic [RW-1:0] staged,
  output logic          phase_next
);
  logic [RW-1:0] cnt, act, pend_ratio;
  logic          pending, term;

  assign term = (cnt == act - RW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      act        <= RW'(RESET_RAT);
      pend_ratio <= RW'(RESET_RAT);
      pending    <= 1'b0;
    end else begin
      if (reload_req) begin
        pending    <= 1'b1;
        pend_ratio <= legal_ratio(staged);
      end else if (term) begin
        pending <= 1'b0;
      end
      if (term) begin
        cnt <= '0;
        if (pending) act <= pend_ratio;
      end else begin
        cnt <= cnt + RW'(1);
      end
    end
  end

  // Value the output phase takes at the next edge: high for the first act/2 counts
  assign phase_next = term ? 1'b1 : ((cnt + RW'(1)) < (act >> 1));

  assert_ratio_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act == RW'(4)) || (act == RW'(5)) || (act == RW'(6)) || (act == RW'(8)));
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < act);
  assert_switch_at_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act) |-> (cnt == '0));
  assert_pending_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(reload_req));
endmodule

// File: rtl/ckdiv_gate.sv
module ckdiv_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic phase_next,
  input  logic enable,
  output logic clk_out
);
  logic gate_q, out_q, gate_eff;

  // The gate may follow enable only while the output is going to be low
  assign gate_eff = phase_next ? gate_q : enable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      gate_q <= gate_eff;
      out_q  <= phase_next & gate_eff;
    end
  end

  assign clk_out = out_q;

  assert_no_short_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |=> out_q);
  assert_no_short_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_q) |=> !out_q);
endmodule

// File: rtl/reload_clkdiv.sv
module reload_clkdiv
  import ckdiv_pkg::*;
#(
  parameter int AW         = 4,
  parameter int DW         = 32,
  parameter int CTRL_ADDR  = 0,
  parameter int RATIO_ADDR = 8,
  parameter int CLK_IDX    = 1,
  parameter int EN_BASE    = 24,
  parameter int TRIG_BIT   = 8,
  parameter int FIELD_LSB  = 8,
  parameter int RESET_RAT  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          clk_out
);
  localparam int RW = RATIO_W;

  logic [RW-1:0] staged;
  logic          enable, reload_req, phase_next;

  ckdiv_regs #(
    .AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR), .RATIO_ADDR(RATIO_ADDR),
    .CLK_IDX(CLK_IDX), .EN_BASE(EN_BASE), .TRIG_BIT(TRIG_BIT),
    .FIELD_LSB(FIELD_LSB), .RW(RW), .RESET_RAT(RESET_RAT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .staged(staged),
    .enable(enable), .reload_req(reload_req)
  );

  ckdiv_count #(.RW(RW), .RESET_RAT(RESET_RAT)) u_count (
    .clk(clk), .rst_n(rst_n), .reload_req(reload_req), .staged(staged),
    .phase_next(phase_next)
  );

  ckdiv_gate u_gate (
    .clk(clk), .rst_n(rst_n), .phase_next(phase_next), .enable(enable),
    .clk_out(clk_out)
  );
endmodule

// File: tb/sim_reload_clkdiv.sv
`timescale 1ns/1ps
module sim_reload_clkdiv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        clk_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  localparam logic [31:0] EN    = 32'h0200_0000; // bit 25
  localparam logic [31:0] FORCE = 32'h0000_0002; // bit 1
  localparam logic [31:0] TRIG  = 32'h0000_0100; // bit 8

  reload_clkdiv u0 (.*);

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic measure(output int hi, output int lo);
    hi = 0; lo = 0;
    for (int i = 0; i < 40 && clk_out; i++) @(negedge clk);
    for (int i = 0; i < 40 && !clk_out; i++) @(negedge clk);
    for (int i = 0; i < 40 && clk_out; i++) begin hi++; @(negedge clk); end
    for (int i = 0; i < 40 && !clk_out; i++) begin lo++; @(negedge clk); end
  endtask

  task automatic expect_ratio(input int n, input string tag);
    int hi, lo;
    measure(hi, lo);
    measure(hi, lo);
    check(hi == n / 2, {tag, " high"}, hi, n / 2);
    check(lo == n - n / 2, {tag, " low"}, lo, n - n / 2);
  endtask

  task automatic load_ratio(input logic [31:0] word);
    wr(4'd8, word);
    wr(4'd0, EN | FORCE | TRIG);
    wr(4'd0, EN);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    int highs = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (clk_out) highs++; end
    check(highs == 0, "R1 output low after reset", highs, 0);
    rd(4'd0, d); check(d == 32'h0, "R1 control reset", d, 0);
    rd(4'd8, d); check(d == 32'h800, "R1 ratio reset", d, 32'h800);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(4'd8, 32'hFFFF_C5FF);
    rd(4'd8, d); check(d == 32'hFFFF_C5FF, "R2 R3 ratio readback", d, 32'hFFFF_C5FF);
    wr(4'd0, 32'hA400_00F0);
    rd(4'd0, d); check(d == 32'hA400_00F0, "R2 control readback", d, 32'hA400_00F0);
    wr(4'd4, 32'h1234_5678);
    rd(4'd4, d); check(d == 32'h0, "R2 unmapped reads zero", d, 0);
    rd(4'd0, d); check(d == 32'hA400_00F0, "R2 unmapped write ignored", d, 32'hA400_00F0);
    wr(4'd0, 32'h0);
    wr(4'd8, 32'h0000_0800);
  endtask

  task automatic t_default();
    wr(4'd0, EN);
    expect_ratio(8, "R1 R7 default ratio 8");
  endtask

  task automatic t_no_force();
    wr(4'd8, 32'h0000_0500);
    wr(4'd0, EN | TRIG);
    expect_ratio(8, "R4 trigger alone");
    wr(4'd0, EN | FORCE);
    expect_ratio(8, "R4 force alone");
    wr(4'd0, EN);
  endtask

  task automatic t_reload();
    wr(4'd0, EN | FORCE | TRIG);
    wr(4'd0, EN | FORCE | TRIG | 32'hFD);
    wr(4'd0, EN);
    expect_ratio(5, "R5 R7 reload odd ratio 5");
    expect_ratio(5, "R5 ratio held after clear");
    load_ratio(32'h0000_0600);
    expect_ratio(6, "R7 ratio 6");
  endtask

  task automatic t_clamp();
    load_ratio(32'h0000_0200); expect_ratio(4, "R6 value 2 to 4");
    load_ratio(32'h0000_0700); expect_ratio(8, "R6 value 7 to 8");
    load_ratio(32'h0000_0000); expect_ratio(4, "R6 value 0 to 4");
    load_ratio(32'h0000_3F00); expect_ratio(8, "R6 value 63 to 8");
  endtask

  task automatic t_other_bits();
    load_ratio(32'hFFFF_C4FF);
    expect_ratio(4, "R3 outside bits ignored");
  endtask

  task automatic t_disable();
    int hi = 0, lows = 0;
    load_ratio(32'h0000_0600);
    expect_ratio(6, "R8 before disable");
    for (int i = 0; i < 40 && clk_out; i++) @(negedge clk);
    for (int i = 0; i < 40 && !clk_out; i++) @(negedge clk);
    bus_we = 1'b1; bus_addr = 4'd0; bus_wdata = 32'h0;
    for (int i = 0; i < 40 && clk_out; i++) begin
      hi++;
      @(negedge clk);
      bus_we = 1'b0;
    end
    check(hi == 3, "R8 pulse completes after disable", hi, 3);
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (clk_out) lows++; end
    check(lows == 0, "R8 output held low while disabled", lows, 0);
    wr(4'd0, EN);
    expect_ratio(6, "R8 re-enable");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_default();
    t_no_force();
    t_reload();
    t_clamp();
    t_other_bits();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule